// File: doc/BRIEF.md
# Segment and Page Privilege Checker

This unit decides, one request at a time, whether a memory access or a control transfer may proceed. Each request presents the level the code is running at, the 16-bit selector naming the target, and the privilege level found in the target's descriptor. It also presents the kind of request, the privilege level of the gate when the request enters through a gate, and the user-access bit of the target page. The descriptor lookup and the page walk happen elsewhere, and their results arrive here as plain inputs.

One cycle after a valid request, exactly one of three outputs pulses for a single cycle:
- a grant, which carries the level the requester will run at afterwards;
- a protection fault, which reports the offending selector;
- a page fault.

Segment rules decide first, and the page rule applies only when the segment rules allow the request. Level numbers run from 0, the most trusted, to 3, the least trusted.

Top module: `privchk_top`

## Requirements
- R1: While reset is asserted and after its release with no request, `grantValid`, `gpFault`, `pageFault`, `grantLevel` and `faultSelector` are all zero.
- R2: The requested level is selector bits [1:0]. Bits [15:3] (index) and bit 2 (table select) do not affect the decision. On a protection fault, `faultSelector` equals the whole selector of that request; otherwise it is zero.
- R3: A data access (`accKind` = 0) passes the segment check only when max(`curLevel`, requested level) <= `descLevel`. Otherwise it raises a protection fault.
- R4: A direct jump or call (`accKind` = 1) passes the segment check only when `curLevel` == `descLevel`, whatever the requested level is. Otherwise it raises a protection fault.
- R5: A gate entry (`accKind` = 2) passes the segment check only when `curLevel` <= `gateLevel`. When it is granted, `grantLevel` equals `descLevel`.
- R6: A page with `pageUser` = 0 may be accessed only at `curLevel` 0. A request that passes its segment check at any other level raises a page fault instead of a grant.
- R7: When both the segment check and the page check fail, only `gpFault` pulses. Every valid request yields exactly one of `grantValid`, `gpFault` and `pageFault`.
- R8: Results appear on the clock edge after the edge that accepts the request and last one cycle. With `reqValid` low, no output pulses on the following cycle.
- R9: `accKind` = 3 is reserved and always raises a protection fault.
- R10: A granted data access or jump reports `grantLevel` equal to `curLevel`. When there is no grant, `grantLevel` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| accKind | input | 2 | 0 data, 1 direct jump/call, 2 gate entry, 3 reserved |
| curLevel | input | 2 | Level of the running code |
| selector | input | 16 | Target selector: index, table select, requested level |
| descLevel | input | 2 | Privilege level from the target descriptor |
| gateLevel | input | 2 | Privilege level of the gate used |
| pageUser | input | 1 | 1 when the target page is open to all levels |
| grantValid | output | 1 | One-cycle grant pulse |
| gpFault | output | 1 | One-cycle protection fault pulse |
| pageFault | output | 1 | One-cycle page fault pulse |
| grantLevel | output | 2 | Level after the granted request |
| faultSelector | output | 16 | Selector of the faulting request |

## Verification
Hand-picked data accesses set a trusted caller against a weak requested level, and the reverse. These cases show that the larger of the two levels is the one compared, not either level alone. Jumps with a mismatched requested level show that jumps ignore it. Gate entries from weak callers show that the gate level filters the caller and that the descriptor level becomes the new level. Supervisor pages requested at levels 1 and 3, with segment checks that both pass and fail, show that the page rule is checked second and yields to the protection fault. A back-to-back sweep of every combination of kind, levels and page bit, with varied index bits, tells the four segment rules apart and shows that results stay in step under a continuous request stream.

// File: rtl/privchk_pkg.sv
package privchk_pkg;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_JUMP = 2'd1,
    KIND_GATE = 2'd2,
    KIND_RSVD = 2'd3
  } accKind_e;

  // comparison results produced by the datapath
  typedef struct packed {
    logic dataOk;
    logic jumpOk;
    logic gateOk;
    logic pageOk;
  } ruleFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic grant;
    logic genProt;
    logic pageFlt;
    logic levelFromDesc;
  } ctrlStrobe_t;

endpackage

// File: rtl/privchk_datapath.sv
module privchk_datapath
  import privchk_pkg::*;
#(
  parameter int LVL_W     = 2,
  parameter int SEL_W     = 16,
  parameter int SUPER_LVL = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL_W-1:0]  curLevel,
  input  logic [SEL_W-1:0]  selector,
  input  logic [LVL_W-1:0]  descLevel,
  input  logic [LVL_W-1:0]  gateLevel,
  input  logic              pageUser,
  input  ctrlStrobe_t       strobe,
  output ruleFlags_t        flags,
  output logic              grantOut,
  output logic              gpOut,
  output logic              pfOut,
  output logic [LVL_W-1:0]  levelOut,
  output logic [SEL_W-1:0]  faultSelOut
);

  localparam logic [LVL_W-1:0] SUPER_CODE = LVL_W'(SUPER_LVL);

  logic [LVL_W-1:0] reqLevel;
  logic [LVL_W-1:0] effLevel;
  logic [LVL_W-1:0] nextLevel;

  // requested level sits in the low bits of the selector
  assign reqLevel = selector[LVL_W-1:0];

  always_comb begin
    effLevel       = (curLevel > reqLevel) ? curLevel : reqLevel;
    flags.dataOk   = (effLevel <= descLevel);
    flags.jumpOk   = (curLevel == descLevel);
    flags.gateOk   = (curLevel <= gateLevel);
    flags.pageOk   = pageUser || (curLevel == SUPER_CODE);
    nextLevel      = strobe.levelFromDesc ? descLevel : curLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantOut    <= 1'b0;
      gpOut       <= 1'b0;
      pfOut       <= 1'b0;
      levelOut    <= '0;
      faultSelOut <= '0;
    end else begin
      grantOut    <= strobe.grant;
      gpOut       <= strobe.genProt;
      pfOut       <= strobe.pageFlt;
      levelOut    <= strobe.grant ? nextLevel : '0;
      faultSelOut <= strobe.genProt ? selector : '0;
    end
  end

endmodule

// File: rtl/privchk_control.sv
module privchk_control
  import privchk_pkg::*;
(
  input  logic        reqValid,
  input  logic [1:0]  accKind,
  input  ruleFlags_t  flags,
  output ctrlStrobe_t strobe
);

  accKind_e kind;
  logic     segOk;

  assign kind = accKind_e'(accKind);

  always_comb begin
    unique case (kind)
      KIND_DATA: segOk = flags.dataOk;
      KIND_JUMP: segOk = flags.jumpOk;
      KIND_GATE: segOk = flags.gateOk;
      default:   segOk = 1'b0;
    endcase
    // segment failure outranks the page check
    strobe.genProt       = reqValid && !segOk;
    strobe.pageFlt       = reqValid && segOk && !flags.pageOk;
    strobe.grant         = reqValid && segOk && flags.pageOk;
    strobe.levelFromDesc = (kind == KIND_GATE);
  end

endmodule

// File: rtl/privchk_top.sv
module privchk_top
  import privchk_pkg::*;
#(
  parameter int LVL_W     = 2,
  parameter int SEL_W     = 16,
  parameter int SUPER_LVL = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       accKind,
  input  logic [LVL_W-1:0] curLevel,
  input  logic [SEL_W-1:0] selector,
  input  logic [LVL_W-1:0] descLevel,
  input  logic [LVL_W-1:0] gateLevel,
  input  logic             pageUser,
  output logic             grantValid,
  output logic             gpFault,
  output logic             pageFault,
  output logic [LVL_W-1:0] grantLevel,
  output logic [SEL_W-1:0] faultSelector
);

  ruleFlags_t  flags;
  ctrlStrobe_t strobe;

  privchk_control ctrl_i (
    .reqValid (reqValid),
    .accKind  (accKind),
    .flags    (flags),
    .strobe   (strobe)
  );

  privchk_datapath #(
    .LVL_W     (LVL_W),
    .SEL_W     (SEL_W),
    .SUPER_LVL (SUPER_LVL)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .curLevel    (curLevel),
    .selector    (selector),
    .descLevel   (descLevel),
    .gateLevel   (gateLevel),
    .pageUser    (pageUser),
    .strobe      (strobe),
    .flags       (flags),
    .grantOut    (grantValid),
    .gpOut       (gpFault),
    .pfOut       (pageFault),
    .levelOut    (grantLevel),
    .faultSelOut (faultSelector)
  );

endmodule

// File: rtl/privchk_checker.sv
module privchk_checker #(
  parameter int LVL_W = 2,
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       accKind,
  input logic [LVL_W-1:0] curLevel,
  input logic [SEL_W-1:0] selector,
  input logic [LVL_W-1:0] descLevel,
  input logic [LVL_W-1:0] gateLevel,
  input logic             pageUser,
  input logic             grantValid,
  input logic             gpFault,
  input logic             pageFault,
  input logic [LVL_W-1:0] grantLevel,
  input logic [SEL_W-1:0] faultSelector
);

  logic [LVL_W-1:0] chkEff;
  assign chkEff = (curLevel > selector[LVL_W-1:0]) ? curLevel : selector[LVL_W-1:0];

  // R1: reset holds outputs quiet on the following edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !(grantValid || gpFault || pageFault));

  // R8: no request, no pulse
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !(grantValid || gpFault || pageFault));

  // R7: exactly one outcome per request
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $onehot({grantValid, gpFault, pageFault}));

  // R3: weak effective level on data access faults
  a_r3_data_fault: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd0 && chkEff > descLevel) |=> gpFault);

  // R4: mismatched jump faults
  a_r4_jump_fault: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd1 && curLevel != descLevel) |=> gpFault);

  // R5: granted gate switches to the descriptor level
  a_r5_gate_level: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd2 && curLevel <= gateLevel && pageUser)
      |=> (grantValid && grantLevel == $past(descLevel)));

  // R6: supervisor page never granted above level 0
  a_r6_page_block: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !pageUser && curLevel != '0) |=> !grantValid);

  // R9: reserved kind always faults
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accKind == 2'd3) |=> gpFault);

  // R2: faulting selector reported intact
  a_r2_fault_sel: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (gpFault ? (faultSelector == $past(selector)) : (faultSelector == '0)));

endmodule

bind privchk_top privchk_checker #(.LVL_W(LVL_W), .SEL_W(SEL_W)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .accKind       (accKind),
  .curLevel      (curLevel),
  .selector      (selector),
  .descLevel     (descLevel),
  .gateLevel     (gateLevel),
  .pageUser      (pageUser),
  .grantValid    (grantValid),
  .gpFault       (gpFault),
  .pageFault     (pageFault),
  .grantLevel    (grantLevel),
  .faultSelector (faultSelector)
);

// File: tb/privchk_top_tb_top.sv
`timescale 1ns/1ps
module privchk_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  accKind;
  logic [1:0]  curLevel;
  logic [15:0] selector;
  logic [1:0]  descLevel;
  logic [1:0]  gateLevel;
  logic        pageUser;
  logic        grantValid, gpFault, pageFault;
  logic [1:0]  grantLevel;
  logic [15:0] faultSelector;

  always #10 clk = ~clk;

  privchk_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accKind(accKind),
    .curLevel(curLevel), .selector(selector), .descLevel(descLevel),
    .gateLevel(gateLevel), .pageUser(pageUser), .grantValid(grantValid),
    .gpFault(gpFault), .pageFault(pageFault), .grantLevel(grantLevel),
    .faultSelector(faultSelector)
  );

  typedef struct {
    logic        g;
    logic        gp;
    logic        pf;
    logic [1:0]  lvl;
    logic [15:0] fs;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;
  logic sampledValid = 1'b0;

  function automatic exp_t model(input logic [1:0] k, input logic [1:0] c,
                                 input logic [15:0] s, input logic [1:0] d,
                                 input logic [1:0] gl, input logic pu, input string tag);
    exp_t e;
    logic [1:0] eff;
    logic segOk, pgOk;
    eff = (c > s[1:0]) ? c : s[1:0];
    case (k)
      2'd0: segOk = (eff <= d);
      2'd1: segOk = (c == d);
      2'd2: segOk = (c <= gl);
      default: segOk = 1'b0;
    endcase
    pgOk  = pu || (c == 2'd0);
    e.gp  = !segOk;
    e.pf  = segOk && !pgOk;
    e.g   = segOk && pgOk;
    e.lvl = e.g ? ((k == 2'd2) ? d : c) : 2'd0;
    e.fs  = e.gp ? s : 16'd0;
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [1:0] k, input logic [1:0] c, input logic [15:0] s,
                      input logic [1:0] d, input logic [1:0] gl, input logic pu,
                      input string tag);
    @(negedge clk);
    reqValid  = 1'b1;
    accKind   = k;
    curLevel  = c;
    selector  = s;
    descLevel = d;
    gateLevel = gl;
    pageUser  = pu;
    expQ.push_back(model(k, c, s, d, gl, pu, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  always @(posedge clk) sampledValid <= reqValid && rstN;

  // monitor: compares registered results half a cycle after each edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (sampledValid) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if ({grantValid, gpFault, pageFault, grantLevel, faultSelector} !==
            {e.g, e.gp, e.pf, e.lvl, e.fs}) begin
          bad++;
          $display("FAIL %s: actual g/gp/pf=%b%b%b lvl=%0d sel=%h expected g/gp/pf=%b%b%b lvl=%0d sel=%h",
                   e.tag, grantValid, gpFault, pageFault, grantLevel, faultSelector,
                   e.g, e.gp, e.pf, e.lvl, e.fs);
        end
      end else begin
        total++;
        if (grantValid || gpFault || pageFault) begin
          bad++;
          $display("FAIL R8 idle: actual g/gp/pf=%b%b%b expected 000",
                   grantValid, gpFault, pageFault);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b1; accKind = 2'd0; curLevel = 2'd0;
    selector = 16'hFFFF; descLevel = 2'd3; gateLevel = 2'd0; pageUser = 1'b1;
    repeat (3) @(negedge clk);
    total++;
    if ({grantValid, gpFault, pageFault, grantLevel, faultSelector} !== 21'd0) begin
      bad++;
      $display("FAIL R1 reset: actual=%b%b%b %0d %h expected=000 0 0000",
               grantValid, gpFault, pageFault, grantLevel, faultSelector);
    end
    reqValid = 1'b0;
    rstN = 1'b1;
    idle(2);
    total++;
    if ({grantValid, gpFault, pageFault, grantLevel, faultSelector} !== 21'd0) begin
      bad++;
      $display("FAIL R1 after release: actual=%b%b%b %0d %h expected=000 0 0000",
               grantValid, gpFault, pageFault, grantLevel, faultSelector);
    end

    // R3 data access, effective level is the larger of current and requested
    send(2'd0, 2'd0, 16'h0008, 2'd0, 2'd0, 1'b1, "R3 ring0 data");
    send(2'd0, 2'd3, 16'h0013, 2'd0, 2'd0, 1'b1, "R3 weak caller");
    send(2'd0, 2'd0, 16'h002B, 2'd0, 2'd0, 1'b1, "R3 weak requested level");
    send(2'd0, 2'd0, 16'h002B, 2'd3, 2'd0, 1'b1, "R3 requested level fits");
    send(2'd0, 2'd2, 16'h0031, 2'd2, 2'd0, 1'b1, "R10 data level");
    idle(1);
    // R4 jumps
    send(2'd1, 2'd2, 16'h0043, 2'd2, 2'd0, 1'b1, "R4 same level, rpl ignored");
    send(2'd1, 2'd3, 16'h0053, 2'd0, 2'd3, 1'b1, "R4 upward jump");
    send(2'd1, 2'd0, 16'h0060, 2'd3, 2'd3, 1'b1, "R4 downward jump");
    // R5 gates
    send(2'd2, 2'd3, 16'h0073, 2'd0, 2'd3, 1'b1, "R5 open gate");
    send(2'd2, 2'd3, 16'h0083, 2'd0, 2'd0, 1'b1, "R5 closed gate");
    send(2'd2, 2'd1, 16'h0091, 2'd0, 2'd2, 1'b1, "R5 level switch");
    idle(2);
    // R6 / R7 page rule and priority
    send(2'd0, 2'd3, 16'h00A3, 2'd3, 2'd0, 1'b0, "R6 user on supervisor page");
    send(2'd0, 2'd0, 16'h00B0, 2'd0, 2'd0, 1'b0, "R6 ring0 on supervisor page");
    send(2'd0, 2'd1, 16'h00C1, 2'd1, 2'd0, 1'b0, "R6 level1 on supervisor page");
    send(2'd0, 2'd3, 16'h00D3, 2'd0, 2'd0, 1'b0, "R7 both faults");
    send(2'd3, 2'd0, 16'h00E4, 2'd0, 2'd0, 1'b1, "R9 reserved kind");
    idle(1);

    // exhaustive sweep, back to back
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 4; c++)
        for (int d = 0; d < 4; d++)
          for (int r = 0; r < 4; r++)
            for (int g = 0; g < 4; g++)
              for (int p = 0; p < 2; p++) begin
                logic [15:0] s;
                string tag;
                s = {13'(k*997 + c*131 + d*37 + g*11 + p*5 + r), 1'(c ^ g), 2'(r)};
                case (k)
                  0: tag = "R3 sweep";
                  1: tag = "R4 sweep";
                  2: tag = "R5 sweep";
                  default: tag = "R9 sweep";
                endcase
                if (p == 0 && c != 0) tag = {tag, " R6 R2"};
                else tag = {tag, " R2"};
                send(2'(k), 2'(c), s, 2'(d), 2'(g), p[0], tag);
              end
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule